// File: doc/BRIEF.md
# Page program controller for a parallel write-protected byte memory

This block is the host-side master that programs one page of a parallel memory which only accepts writes after an unlock code. The host first fills a 64-byte source buffer. It then pulses a start command with a page number, a starting byte offset inside that page and a byte count from 1 to 64. The controller sends the three-write unlock code and then loads the bytes, one write strobe each. Every load lands inside the page, and the offset wraps inside the page. Each strobe is timed to meet a minimum low width, a minimum high width and a maximum start-to-start gap.

After the last load, the controller reads back the last address written. It repeats this read at a fixed interval until bit 7 of the read data equals bit 7 of the last byte written. When that happens it pulses `done_o`. If the bit has not settled within a cycle limit, it pulses `err_o` instead. Both pulses return the controller to idle. All timing limits are parameters given in clock cycles. The memory-side bus uses separate data-in and data-out vectors, with active-low chip enable, output enable and write enable.

Top module: `page_prog_ctrl`

## Requirements
- R1: After reset, mem_ce_no, mem_oe_no and mem_we_no are high, and busy_o, done_o and err_o are low.
- R2: Each accepted start first issues three writes in this order: data 8'hAA to address 15'h5555, then 8'h55 to 15'h2AAA, then 8'hA0 to 15'h5555. Data loads follow only after all three.
- R3: Load k (k = 0 to count_i-1) writes buffer entry k to address {page_i, (offset_i+k) mod 64}. Page bits 14:6 are therefore equal on every load, and exactly count_i loads are made.
- R4: mem_we_no stays low for at least WP_CYC cycles per write, and stays high for at least WPH_CYC cycles between two writes.
- R5: Consecutive falling edges of mem_we_no within one operation are at most BLC_CYC cycles apart.
- R6: mem_oe_no is high during every cycle in which mem_we_no is low.
- R7: After the last load, the controller only reads. Each read drives the last written address, with mem_oe_no low and mem_we_no high. It pulses done_o for one cycle at the first read whose bit 7 equals bit 7 of the last byte written.
- R8: If no read matches within TIMEOUT_CYC cycles of polling, err_o pulses for one cycle, done_o stays low and the controller returns to idle.
- R9: busy_o is high from the cycle after an accepted start until the cycle of done_o or err_o. A start seen while busy has no effect on the operation in progress.
- R10: A start with count_i equal to 0 or greater than 64 is ignored: busy_o stays low and no bus cycle is made.
- R11: A write to the source buffer (buf_we_i, buf_idx_i, buf_data_i) stores the byte that a later load k = buf_idx_i sends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| buf_we_i | input | 1 | Source buffer write strobe |
| buf_idx_i | input | 6 | Source buffer entry index |
| buf_data_i | input | 8 | Source buffer write data |
| start_i | input | 1 | Start command pulse |
| page_i | input | 9 | Page number (address bits 14:6) |
| offset_i | input | 6 | Byte offset of the first load in the page |
| count_i | input | 7 | Number of bytes to load, 1 to 64 |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle pulse: programming completed |
| err_o | output | 1 | One-cycle pulse: polling timed out |
| mem_ce_no | output | 1 | Memory chip enable, active low |
| mem_oe_no | output | 1 | Memory output enable, active low |
| mem_we_no | output | 1 | Memory write enable, active low |
| mem_addr_o | output | 15 | Memory address |
| mem_dq_o | output | 8 | Data driven to the memory |
| mem_dq_i | input | 8 | Data read from the memory |

## Verification
Most wrong internal states show up on the bus well before done_o. A wrong step counter or a wrong unlock table changes one of the first three strobes, and so shows within about 3 × (WP_CYC+WPH_CYC) cycles of the start. An offset or buffer index error shows as a wrong address or data byte at the load where it occurs. A bad strobe counter shows as a low or high width out of range on the very next strobe. Faults in the poll or timeout path appear later: done_o or err_o comes at the wrong time, from the wrong address, or with the wrong flag, and at the latest one poll interval after the condition occurs.

// File: rtl/ppc_pkg.sv
package ppc_pkg;

  typedef enum logic [2:0] {
    CT_IDLE, CT_UNLOCK, CT_LOAD, CT_POLL_GAP, CT_POLL_RD
  } ctl_st_e;

  typedef enum logic [2:0] {
    BS_IDLE, BS_SETUP, BS_LOW, BS_HIGH, BS_READ
  } bus_st_e;

  localparam int unsigned UNLOCK_LEN = 3;

  function automatic logic [14:0] unlock_addr(input logic [1:0] idx);
    return (idx == 2'd1) ? 15'h2AAA : 15'h5555;
  endfunction

  function automatic logic [7:0] unlock_data(input logic [1:0] idx);
    case (idx)
      2'd0:    return 8'hAA;
      2'd1:    return 8'h55;
      default: return 8'hA0;
    endcase
  endfunction

endpackage

// File: rtl/ppc_src_buf.sv
module ppc_src_buf #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned DEPTH  = 64,
  localparam int unsigned IDX_W = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              we_i,
  input  logic [IDX_W-1:0]  widx_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [IDX_W-1:0]  ridx_i,
  output logic [DATA_W-1:0] rdata_o
);

  logic [DATA_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[widx_i] <= wdata_i;
  end

  assign rdata_o = mem_q[ridx_i];

endmodule

// File: rtl/ppc_bus_seq.sv
module ppc_bus_seq
  import ppc_pkg::*;
#(
  parameter int unsigned ADDR_W  = 15,
  parameter int unsigned DATA_W  = 8,
  parameter int unsigned WP_CYC  = 26,
  parameter int unsigned WPH_CYC = 13,
  parameter int unsigned RD_CYC  = 26,
  localparam int unsigned MAX_C  = (WP_CYC > WPH_CYC) ?
                                   ((WP_CYC > RD_CYC) ? WP_CYC : RD_CYC) :
                                   ((WPH_CYC > RD_CYC) ? WPH_CYC : RD_CYC),
  localparam int unsigned CNT_W  = $clog2(MAX_C + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              idle_o,
  output logic              ack_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic              mem_ce_no,
  output logic              mem_oe_no,
  output logic              mem_we_no,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_dq_o,
  input  logic [DATA_W-1:0] mem_dq_i
);

  bus_st_e           st_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] data_q, rdata_q;
  logic              ack_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= BS_IDLE;
      cnt_q   <= '0;
      addr_q  <= '0;
      data_q  <= '0;
      rdata_q <= '0;
      ack_q   <= 1'b0;
    end else begin
      ack_q <= 1'b0;
      unique case (st_q)
        BS_IDLE: if (req_i) begin
          addr_q <= addr_i;
          data_q <= wdata_i;
          if (wr_i) begin
            st_q <= BS_SETUP;
          end else begin
            st_q  <= BS_READ;
            cnt_q <= CNT_W'(RD_CYC - 1);
          end
        end
        BS_SETUP: begin
          st_q  <= BS_LOW;
          cnt_q <= CNT_W'(WP_CYC - 1);
        end
        BS_LOW: begin
          if (cnt_q == '0) begin
            st_q  <= BS_HIGH;
            cnt_q <= CNT_W'(WPH_CYC - 1);
          end else cnt_q <= cnt_q - 1'b1;
        end
        BS_HIGH: begin
          if (cnt_q == '0) begin
            st_q  <= BS_IDLE;
            ack_q <= 1'b1;
          end else cnt_q <= cnt_q - 1'b1;
        end
        BS_READ: begin
          if (cnt_q == '0) begin
            st_q    <= BS_IDLE;
            ack_q   <= 1'b1;
            rdata_q <= mem_dq_i;
          end else cnt_q <= cnt_q - 1'b1;
        end
        default: st_q <= BS_IDLE;
      endcase
    end
  end

  assign idle_o     = (st_q == BS_IDLE);
  assign ack_o      = ack_q;
  assign rdata_o    = rdata_q;
  assign mem_ce_no  = (st_q == BS_IDLE);
  assign mem_we_no  = (st_q != BS_LOW);
  assign mem_oe_no  = (st_q != BS_READ);
  assign mem_addr_o = addr_q;
  assign mem_dq_o   = data_q;

  // independent run-length of the low strobe
  logic [CNT_W:0] low_run_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) low_run_q <= '0;
    else if (!mem_we_no) begin
      if (low_run_q != '1) low_run_q <= low_run_q + 1'b1;
    end else low_run_q <= '0;
  end

  AST_WE_LOW_MIN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(mem_we_no) |-> (low_run_q >= (CNT_W+1)'(WP_CYC))); // R4

  AST_OE_OFF_IN_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(mem_we_no) |-> ($past(mem_oe_no) && mem_oe_no)); // R6

  AST_REQ_WHEN_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_o |-> $past(st_q != BS_IDLE)); // R7

endmodule

// File: rtl/page_prog_ctrl.sv
module page_prog_ctrl
  import ppc_pkg::*;
#(
  parameter int unsigned PG_W        = 9,
  parameter int unsigned PAGE_BYTES  = 64,
  parameter int unsigned DATA_W      = 8,
  parameter int unsigned WP_CYC      = 26,
  parameter int unsigned WPH_CYC     = 13,
  parameter int unsigned BLC_CYC     = 18750,
  parameter int unsigned RD_CYC      = 26,
  parameter int unsigned POLL_CYC    = 125,
  parameter int unsigned TIMEOUT_CYC = 1375000,
  localparam int unsigned OFF_W      = $clog2(PAGE_BYTES),
  localparam int unsigned ADDR_W     = PG_W + OFF_W,
  localparam int unsigned CNT_W      = OFF_W + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              buf_we_i,
  input  logic [OFF_W-1:0]  buf_idx_i,
  input  logic [DATA_W-1:0] buf_data_i,
  input  logic              start_i,
  input  logic [PG_W-1:0]   page_i,
  input  logic [OFF_W-1:0]  offset_i,
  input  logic [CNT_W-1:0]  count_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              err_o,
  output logic              mem_ce_no,
  output logic              mem_oe_no,
  output logic              mem_we_no,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_dq_o,
  input  logic [DATA_W-1:0] mem_dq_i
);

  localparam int unsigned PC_W  = $clog2(POLL_CYC + 1);
  localparam int unsigned TMO_W = $clog2(TIMEOUT_CYC + 1);
  localparam int unsigned GAP_W = $clog2(BLC_CYC + 2);

  ctl_st_e           st_q;
  logic [CNT_W-1:0]  step_q, cnt_q;
  logic [PG_W-1:0]   page_q;
  logic [OFF_W-1:0]  off_q;
  logic [ADDR_W-1:0] last_addr_q;
  logic              last_d7_q;
  logic              pend_q;
  logic [PC_W-1:0]   poll_cnt_q;
  logic [TMO_W-1:0]  tmo_cnt_q;
  logic              done_q, err_q;

  logic              req, req_wr, seq_idle, seq_ack;
  logic [ADDR_W-1:0] req_addr;
  logic [DATA_W-1:0] req_data, buf_rd, seq_rdata;
  logic              start_ok;

  ppc_src_buf #(.DATA_W(DATA_W), .DEPTH(PAGE_BYTES)) u_buf (
    .clk_i   (clk_i),
    .we_i    (buf_we_i),
    .widx_i  (buf_idx_i),
    .wdata_i (buf_data_i),
    .ridx_i  (step_q[OFF_W-1:0]),
    .rdata_o (buf_rd)
  );

  assign start_ok = start_i && (st_q == CT_IDLE) && (count_i != '0) &&
                    (count_i <= CNT_W'(PAGE_BYTES));

  assign req    = ((st_q == CT_UNLOCK) || (st_q == CT_LOAD) || (st_q == CT_POLL_RD)) && !pend_q;
  assign req_wr = (st_q != CT_POLL_RD);

  always_comb begin
    req_addr = last_addr_q;
    req_data = buf_rd;
    if (st_q == CT_UNLOCK) begin
      req_addr = ADDR_W'(unlock_addr(step_q[1:0]));
      req_data = DATA_W'(unlock_data(step_q[1:0]));
    end else if (st_q == CT_LOAD) begin
      req_addr = {page_q, off_q + step_q[OFF_W-1:0]};
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q        <= CT_IDLE;
      step_q      <= '0;
      cnt_q       <= '0;
      page_q      <= '0;
      off_q       <= '0;
      last_addr_q <= '0;
      last_d7_q   <= 1'b0;
      pend_q      <= 1'b0;
      poll_cnt_q  <= '0;
      tmo_cnt_q   <= '0;
      done_q      <= 1'b0;
      err_q       <= 1'b0;
    end else begin
      done_q <= 1'b0;
      err_q  <= 1'b0;
      if (req) pend_q <= 1'b1;
      else if (seq_ack) pend_q <= 1'b0;
      if ((st_q == CT_POLL_GAP) || (st_q == CT_POLL_RD)) begin
        if (tmo_cnt_q != '1) tmo_cnt_q <= tmo_cnt_q + 1'b1;
      end
      unique case (st_q)
        CT_IDLE: if (start_ok) begin
          st_q   <= CT_UNLOCK;
          step_q <= '0;
          page_q <= page_i;
          off_q  <= offset_i;
          cnt_q  <= count_i;
        end
        CT_UNLOCK: if (seq_ack) begin
          if (step_q == CNT_W'(UNLOCK_LEN - 1)) begin
            st_q   <= CT_LOAD;
            step_q <= '0;
          end else step_q <= step_q + 1'b1;
        end
        CT_LOAD: begin
          if (req) begin
            last_addr_q <= req_addr;
            last_d7_q   <= req_data[DATA_W-1];
          end
          if (seq_ack) begin
            if (step_q == cnt_q - 1'b1) begin
              st_q       <= CT_POLL_GAP;
              poll_cnt_q <= '0;
              tmo_cnt_q  <= '0;
            end else step_q <= step_q + 1'b1;
          end
        end
        CT_POLL_GAP: begin
          if (poll_cnt_q >= PC_W'(POLL_CYC - 1)) st_q <= CT_POLL_RD;
          else poll_cnt_q <= poll_cnt_q + 1'b1;
        end
        CT_POLL_RD: if (seq_ack) begin
          if (seq_rdata[DATA_W-1] == last_d7_q) begin
            st_q   <= CT_IDLE;
            done_q <= 1'b1;
          end else if (tmo_cnt_q >= TMO_W'(TIMEOUT_CYC)) begin
            st_q  <= CT_IDLE;
            err_q <= 1'b1;
          end else begin
            st_q       <= CT_POLL_GAP;
            poll_cnt_q <= '0;
          end
        end
        default: st_q <= CT_IDLE;
      endcase
    end
  end

  ppc_bus_seq #(
    .ADDR_W (ADDR_W), .DATA_W (DATA_W),
    .WP_CYC (WP_CYC), .WPH_CYC(WPH_CYC), .RD_CYC(RD_CYC)
  ) u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .req_i      (req),
    .wr_i       (req_wr),
    .addr_i     (req_addr),
    .wdata_i    (req_data),
    .idle_o     (seq_idle),
    .ack_o      (seq_ack),
    .rdata_o    (seq_rdata),
    .mem_ce_no  (mem_ce_no),
    .mem_oe_no  (mem_oe_no),
    .mem_we_no  (mem_we_no),
    .mem_addr_o (mem_addr_o),
    .mem_dq_o   (mem_dq_o),
    .mem_dq_i   (mem_dq_i)
  );

  assign busy_o = (st_q != CT_IDLE);
  assign done_o = done_q;
  assign err_o  = err_q;

  // strobe-to-strobe window tracking
  logic             we_d_q, in_op_q;
  logic [GAP_W-1:0] gap_q;
  logic             we_fall;
  assign we_fall = we_d_q && !mem_we_no;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      we_d_q  <= 1'b1;
      in_op_q <= 1'b0;
      gap_q   <= '0;
    end else begin
      we_d_q <= mem_we_no;
      if (!busy_o) in_op_q <= 1'b0;
      else if (we_fall) in_op_q <= 1'b1;
      if (we_fall) gap_q <= GAP_W'(1);
      else if (gap_q != '1) gap_q <= gap_q + 1'b1;
    end
  end

  AST_LOAD_WINDOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_fall && in_op_q) |-> (gap_q <= GAP_W'(BLC_CYC))); // R5

  AST_SAME_PAGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((st_q == CT_LOAD) && !mem_we_no) |-> (mem_addr_o[ADDR_W-1:OFF_W] == page_q)); // R3

  AST_POLL_NO_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((st_q == CT_POLL_GAP) || (st_q == CT_POLL_RD)) |-> mem_we_no); // R7

  AST_DONE_ERR_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(done_o && err_o)); // R8

  AST_BUSY_END: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> (done_o || err_o)); // R9

  AST_START_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && start_i) |=> ($stable(page_q) && $stable(cnt_q))); // R9

  AST_SEQ_FREE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req |-> seq_idle); // R7

endmodule

// File: tb/page_prog_ctrl_tb.sv
module page_prog_ctrl_tb;

  localparam int WP = 4, WPH = 3, BLC = 40, RD = 3, POLL = 5, TMO = 600, PROG = 200;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        buf_we = 1'b0;
  logic [5:0]  buf_idx = '0;
  logic [7:0]  buf_data = '0;
  logic        start = 1'b0;
  logic [8:0]  page = '0;
  logic [5:0]  offset = '0;
  logic [6:0]  count = '0;
  logic        busy, done, err, ce_n, oe_n, we_n;
  logic [14:0] addr;
  logic [7:0]  dq_o, dq_i;

  always #4 clk = ~clk;

  page_prog_ctrl #(
    .WP_CYC(WP), .WPH_CYC(WPH), .BLC_CYC(BLC), .RD_CYC(RD),
    .POLL_CYC(POLL), .TIMEOUT_CYC(TMO)
  ) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .buf_we_i(buf_we), .buf_idx_i(buf_idx),
    .buf_data_i(buf_data), .start_i(start), .page_i(page), .offset_i(offset),
    .count_i(count), .busy_o(busy), .done_o(done), .err_o(err),
    .mem_ce_no(ce_n), .mem_oe_no(oe_n), .mem_we_no(we_n), .mem_addr_o(addr),
    .mem_dq_o(dq_o), .mem_dq_i(dq_i)
  );

  int checks = 0, errors = 0;
  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // memory model
  logic [7:0]  mem [32768];
  logic [14:0] log_a [80];
  logic [7:0]  log_d [80];
  int   log_n, lo_cnt, hi_cnt, gap_cnt, rd_cnt, rd_bad, prog_cnt;
  int   lo_viol, hi_viol, gap_viol, oe_viol;
  bit   seen_rise, seen_fall, stuck;
  logic [7:0]  last_d;
  logic [14:0] poll_addr;
  logic        prev_we = 1'b1;

  always_comb dq_i = (prog_cnt != 0 || stuck) ? {~last_d[7], last_d[6:0]} : mem[addr];

  always @(negedge clk) begin
    if (!we_n && prev_we) begin
      if (seen_fall && gap_cnt > BLC) gap_viol++;
      if (seen_rise && hi_cnt < WPH) hi_viol++;
      gap_cnt = 0;
      seen_fall = 1;
    end
    if (!we_n && !oe_n) oe_viol++;
    if (we_n && !prev_we) begin
      if (lo_cnt < WP) lo_viol++;
      if (log_n < 80) begin log_a[log_n] = addr; log_d[log_n] = dq_o; end
      if (log_n >= 3) begin mem[addr] = dq_o; last_d = dq_o; end
      log_n++;
      prog_cnt = PROG;
      seen_rise = 1;
      hi_cnt = 0;
    end
    if (!we_n) lo_cnt++; else begin lo_cnt = 0; hi_cnt++; end
    gap_cnt++;
    if (!ce_n && !oe_n && we_n) begin
      rd_cnt++;
      if (addr != poll_addr) rd_bad++;
    end
    if (prog_cnt > 0) prog_cnt--;
    prev_we = we_n;
  end

  task automatic clr_model();
    log_n = 0; lo_cnt = 0; hi_cnt = 0; gap_cnt = 0; rd_cnt = 0; rd_bad = 0;
    lo_viol = 0; hi_viol = 0; gap_viol = 0; oe_viol = 0;
    seen_rise = 0; seen_fall = 0;
  endtask

  task automatic fill_buf(input int seed);
    for (int i = 0; i < 64; i++) begin
      @(negedge clk);
      buf_we = 1; buf_idx = 6'(i); buf_data = 8'(i * 37 + seed);
    end
    @(negedge clk); buf_we = 0;
  endtask

  task automatic pulse_start(input logic [8:0] p, input logic [5:0] o, input logic [6:0] c);
    @(negedge clk);
    start = 1; page = p; offset = o; count = c;
    @(negedge clk);
    start = 0;
  endtask

  task automatic wait_end(output bit got_done, output bit got_err);
    got_done = 0; got_err = 0;
    for (int i = 0; i < 20000; i++) begin
      @(negedge clk);
      if (done) got_done = 1;
      if (err) got_err = 1;
      if (got_done || got_err) break;
    end
  endtask

  task automatic t_reset();
    chk(ce_n && oe_n && we_n, "R1 bus idle", {ce_n, oe_n, we_n}, 3'b111);
    chk(!busy && !done && !err, "R1 flags", {busy, done, err}, 0);
  endtask

  task automatic t_page(input logic [8:0] p, input logic [5:0] o, input int c, input int seed);
    bit gd, ge;
    int bad;
    fill_buf(seed);
    clr_model();
    poll_addr = {p, 6'(o + c - 1)};
    pulse_start(p, o, 7'(c));
    chk(busy, "R9 busy after start", busy, 1);
    wait_end(gd, ge);
    chk(gd && !ge, "R7 done pulse", {gd, ge}, 2'b10);
    @(negedge clk);
    chk(!busy && !done, "R9 busy/done drop", {busy, done}, 0);
    chk(log_n == c + 3, "R3 load count", log_n, c + 3);
    chk(log_a[0] == 15'h5555 && log_d[0] == 8'hAA && log_a[1] == 15'h2AAA &&
        log_d[1] == 8'h55 && log_a[2] == 15'h5555 && log_d[2] == 8'hA0,
        "R2 unlock order", {log_d[0], log_d[1], log_d[2]}, 24'hAA55A0);
    bad = 0;
    for (int k = 0; k < c; k++) begin
      if (log_a[k+3] != {p, 6'(o + k)}) bad++;
      if (log_d[k+3] != 8'(k * 37 + seed)) bad++; // R11 buffer content
    end
    chk(bad == 0, "R3 R11 load addr/data", bad, 0);
    chk(lo_viol == 0 && hi_viol == 0, "R4 strobe widths", lo_viol + hi_viol, 0);
    chk(gap_viol == 0, "R5 load window", gap_viol, 0);
    chk(oe_viol == 0, "R6 oe during write", oe_viol, 0);
    chk(rd_cnt > 0 && rd_bad == 0, "R7 poll address", rd_bad, 0);
  endtask

  task automatic t_busy_ignore();
    bit gd, ge;
    fill_buf(5);
    clr_model();
    poll_addr = {9'h011, 6'd3};
    pulse_start(9'h011, 6'd0, 7'd4);
    repeat (10) @(negedge clk);
    pulse_start(9'h1F0, 6'd9, 7'd20);
    wait_end(gd, ge);
    chk(gd && log_n == 7, "R9 start while busy ignored", log_n, 7);
    chk(log_a[6] == {9'h011, 6'd3}, "R9 page kept", log_a[6], {9'h011, 6'd3});
  endtask

  task automatic t_bad_count();
    clr_model();
    pulse_start(9'h022, 6'd0, 7'd0);
    chk(!busy, "R10 count 0 busy", busy, 0);
    pulse_start(9'h022, 6'd0, 7'd65);
    chk(!busy, "R10 count 65 busy", busy, 0);
    repeat (50) @(negedge clk);
    chk(log_n == 0 && ce_n, "R10 no bus cycle", log_n, 0);
  endtask

  task automatic t_timeout();
    bit gd, ge;
    fill_buf(9);
    clr_model();
    stuck = 1;
    poll_addr = {9'h0AA, 6'd1};
    pulse_start(9'h0AA, 6'd0, 7'd2);
    wait_end(gd, ge);
    chk(ge && !gd, "R8 timeout error", {gd, ge}, 2'b01);
    @(negedge clk);
    chk(!busy && !err, "R8 back to idle", {busy, err}, 0);
    chk(rd_cnt > 0 && rd_bad == 0, "R8 polled last addr", rd_bad, 0);
    stuck = 0;
    repeat (PROG + 5) @(negedge clk);
  endtask

  bit finished = 0;
  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !finished) begin
      errors++; checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    stuck = 0; prog_cnt = 0; last_d = '0; poll_addr = '0;
    clr_model();
    for (int i = 0; i < 32768; i++) mem[i] = 8'hFF;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    repeat (2) @(negedge clk);
    t_page(9'h155, 6'd0, 1, 3);
    t_page(9'h003, 6'd0, 64, 11);
    t_page(9'h1FF, 6'd62, 5, 200);
    t_busy_ignore();
    t_bad_count();
    t_timeout();
    t_page(9'h080, 6'd17, 9, 128);
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule